// File: doc/BRIEF.md
# Low-Side Channel Fault Supervisor

This block is the digital supervisor for one low-side power switch channel. It takes a shared enable, a per-channel on/off command, and four monitor flags that the analog front end has already turned into logic levels. From these it drives the gate-enable of the power stage and a diagnostic line that is low when something is wrong. What the diagnostic means depends on the command state. In the off state it reports the drain voltage: low drain voltage means an open load or a short to ground. In the on state it reports undercurrent, after a filter. When the enable is low, the line is forced low.

Two protection mechanisms stop the channel. The first is a delayed overload trip. An overcurrent flag that lasts a full delay window latches the channel off. The second is an immediate over-temperature cut-off, which is also latched. Both latches clear only when the command goes low. While over-temperature is latched and the command stays high, the overload timer also runs, so the overload latch sets when its window has elapsed. All windows are parameters in clock cycles. Every pin is a plain level signal. There is no data stream, so no valid/ready handshake applies.

Top module: `lsd_channel_supervisor`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `gate_o` and `diag_o` are 0.
- R2: When the synchronised enable is 0, `gate_o` is 0 and `diag_o` is 0, whatever the command and monitor flags are.
- R3: With enable 1 and command 0, `gate_o` is 0 and `diag_o` equals the inverse of `vlow_off_i`. The flag `ilow_on_i` has no effect in this state.
- R4: With enable 1 and command 1 and no fault, `gate_o` is 1. `diag_o` goes to 0 on the UC_CYC-th consecutive clock edge on which `ilow_on_i` is 1 while the gate is on, and is 1 otherwise. The flag `vlow_off_i` has no effect in this state.
- R5: While the channel is on and `ihigh_on_i` is 1 on consecutive edges, the gate stays on for OL_CYC-1 edges. On the OL_CYC-th edge the overload latch sets, and `gate_o` and `diag_o` both go to 0.
- R6: If `ihigh_on_i` returns to 0 for at least one edge before the window expires, the overload timer restarts from zero.
- R7: The overload latch keeps `gate_o` and `diag_o` at 0 after `ihigh_on_i` drops. It clears when the synchronised command is 0, and the channel then works normally again.
- R8: On the first edge that samples `hot_i` as 1, `gate_o` and `diag_o` go to 0. With the command at 1, this state is held after `hot_i` drops, until the command goes low.
- R9: `en_i` and `cmd_i` each pass through a two-flop synchroniser that resets to 0. A change on either pin reaches `gate_o` on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Shared enable, asynchronous |
| cmd_i | input | 1 | Channel on/off command, asynchronous |
| vlow_off_i | input | 1 | Drain voltage below the open-load threshold (meaningful when off) |
| ilow_on_i | input | 1 | Load current below the open-load threshold (meaningful when on) |
| ihigh_on_i | input | 1 | Load current above the overload threshold |
| hot_i | input | 1 | Over-temperature flag |
| gate_o | output | 1 | Power stage gate enable, registered |
| diag_o | output | 1 | Diagnostic, high means healthy, registered |

## Verification
The bench targets the exact edge at which the overload window expires. A timer that is off by one would trip one cycle early or late. The bench also checks that a one-cycle gap in the overcurrent flag restarts the window: a design that only paused its count would trip too soon.

Both latches are checked after their cause has gone away. A design that releases on the fault flag instead of on the command would turn the gate back on. The bench also confirms that the off-state voltage flag and the on-state current flag are each ignored in the other state. A decoder that merged them would pull the diagnostic low in a healthy state.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Monitor flags from the analog front end, already in the clock domain.
  typedef struct packed {
    logic vlow_off;   // drain voltage below open-load level
    logic ilow_on;    // current below open-load level
    logic ihigh_on;   // current above overload level
    logic hot;        // over-temperature
  } mon_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/lsd_trip_timer.sv
// Delay window followed by a sticky latch. The latch is held while keep_i is high.
module lsd_trip_timer #(
  parameter int unsigned CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,     // channel requested on
  input  logic trig_i,    // fault condition
  input  logic keep_i,    // synchronised command; low releases the latch
  output logic lat_n_o,   // latch value after this edge
  output logic lat_q_o
);
  import lsd_pkg::*;

  localparam int unsigned CW = cnt_bits(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          run, set, lat_q, lat_n;

  assign run   = arm_i && trig_i && !lat_q;
  assign set   = run && (cnt_q == LAST);
  assign cnt_n = (run && !set) ? cnt_q + 1'b1 : '0;
  assign lat_n = keep_i && (lat_q || set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      lat_q <= lat_n;
    end
  end

  assign lat_n_o = lat_n;
  assign lat_q_o = lat_q;

  AST_TMR_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) cnt_q < CW'(CYC)); // R5
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !trig_i |=> cnt_q == '0); // R6
  AST_LAT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) lat_q && keep_i |=> lat_q); // R7
  AST_LAT_FREE:    assert property (@(posedge clk) disable iff (!rst_n) !keep_i |=> !lat_q); // R7

endmodule

// File: rtl/lsd_persist.sv
// Raises a flag once a condition has been seen on CYC consecutive edges.
module lsd_persist #(
  parameter int unsigned CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic flag_n_o,
  output logic flag_q_o
);
  import lsd_pkg::*;

  localparam int unsigned CW = cnt_bits(CYC);
  localparam logic [CW-1:0] TOP  = CW'(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          flag_q, flag_n;

  always_comb begin
    if (!cond_i)            cnt_n = '0;
    else if (cnt_q != TOP)  cnt_n = cnt_q + 1'b1;
    else                    cnt_n = cnt_q;
  end

  assign flag_n = cond_i && (cnt_q >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  assign flag_n_o = flag_n;
  assign flag_q_o = flag_q;

  AST_FLT_DROP: assert property (@(posedge clk) disable iff (!rst_n) !cond_i |=> !flag_q); // R4
  AST_FLT_SAT:  assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= TOP); // R4

endmodule

// File: rtl/lsd_channel_supervisor.sv
module lsd_channel_supervisor #(
  parameter int unsigned OL_CYC = 8000,  // overload window, 160 us at 50 MHz
  parameter int unsigned UC_CYC = 2500   // undercurrent filter, 50 us at 50 MHz
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cmd_i,
  input  logic vlow_off_i,
  input  logic ilow_on_i,
  input  logic ihigh_on_i,
  input  logic hot_i,
  output logic gate_o,
  output logic diag_o
);
  import lsd_pkg::*;

  mon_t mon;
  assign mon = '{vlow_off: vlow_off_i, ilow_on: ilow_on_i, ihigh_on: ihigh_on_i, hot: hot_i};

  // Synchronise the asynchronous control pins.
  logic [1:0] ctl_s;
  logic       en_s, cmd_s;

  lsd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({en_i, cmd_i}),
    .q_o   (ctl_s)
  );
  assign en_s  = ctl_s[1];
  assign cmd_s = ctl_s[0];

  logic on_req;
  assign on_req = en_s && cmd_s;

  // Over-temperature latch, released by a low command.
  logic ot_q, ot_n;
  assign ot_n = cmd_s && (ot_q || mon.hot);

  // Overload timer. A latched over-temperature also looks like overcurrent to it.
  logic ol_n, ol_q;
  lsd_trip_timer #(.CYC(OL_CYC)) u_ol (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (on_req),
    .trig_i  (mon.ihigh_on || ot_q),
    .keep_i  (cmd_s),
    .lat_n_o (ol_n),
    .lat_q_o (ol_q)
  );

  // Undercurrent filter, counted only while the gate is actually on.
  logic gate_q, diag_q;
  logic uc_n, uc_q;
  lsd_persist #(.CYC(UC_CYC)) u_uc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond_i   (gate_q && mon.ilow_on),
    .flag_n_o (uc_n),
    .flag_q_o (uc_q)
  );

  // Gate and diagnostic decode.
  logic trip_n, gate_n, diag_n;
  assign trip_n = ol_n || ot_n || mon.hot;
  assign gate_n = on_req && !trip_n;

  always_comb begin
    if (!en_s || trip_n) diag_n = 1'b0;
    else if (cmd_s)      diag_n = !uc_n;
    else                 diag_n = !mon.vlow_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      diag_q <= 1'b0;
      ot_q   <= 1'b0;
    end else begin
      gate_q <= gate_n;
      diag_q <= diag_n;
      ot_q   <= ot_n;
    end
  end

  assign gate_o = gate_q;
  assign diag_o = diag_q;

  AST_EN_OFF:    assert property (@(posedge clk) disable iff (!rst_n) !en_s |=> !gate_o && !diag_o); // R2
  AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n) (ol_q || ot_q) |-> !gate_o && !diag_o); // R7
  AST_HOT_CUT:   assert property (@(posedge clk) disable iff (!rst_n) hot_i |=> !gate_o && !diag_o); // R8
  AST_OT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) ot_q && cmd_s |=> ot_q); // R8
  AST_UC_DIAG:   assert property (@(posedge clk) disable iff (!rst_n) uc_q && gate_o |-> !diag_o); // R4

endmodule

// File: tb/lsd_channel_supervisor_tb.sv
module lsd_channel_supervisor_tb_top;

  localparam int unsigned OL = 16;
  localparam int unsigned UC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cmd = 1'b0, vlow = 1'b0, ilow = 1'b0, ihigh = 1'b0, hot = 1'b0;
  logic gate, diag;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lsd_channel_supervisor #(.OL_CYC(OL), .UC_CYC(UC)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cmd_i(cmd),
    .vlow_off_i(vlow), .ilow_on_i(ilow), .ihigh_on_i(ihigh), .hot_i(hot),
    .gate_o(gate), .diag_o(diag)
  );

  // {en, cmd, vlow, ilow, expected gate, expected diag}
  localparam logic [5:0] VEC [9] = '{
    6'b0000_00, // R2
    6'b0100_00, // R2
    6'b0111_00, // R2
    6'b1000_01, // R3 healthy
    6'b1010_00, // R3 low drain voltage
    6'b1001_01, // R3 ilow ignored
    6'b1100_11, // R4 healthy
    6'b1101_10, // R4 undercurrent
    6'b1110_11  // R4 vlow ignored
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Advance n rising edges, then stop at the falling edge.
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_on();
    en = 1; cmd = 1; vlow = 0; ilow = 0; ihigh = 0; hot = 0;
    edges(8);
  endtask

  task automatic release_and_resume(input string tag);
    ihigh = 0; hot = 0; cmd = 0;
    edges(4);
    chk({tag, " cleared gate"}, gate, 1'b0);
    chk({tag, " cleared diag"}, diag, 1'b1);
    cmd = 1;
    edges(4);
    chk({tag, " resumed gate"}, gate, 1'b1);
  endtask

  initial begin
    // R1: reset state
    en = 1; cmd = 1;
    edges(3);
    chk("R1 gate in reset", gate, 1'b0);
    chk("R1 diag in reset", diag, 1'b0);
    rst_n = 1;
    edges(1);
    chk("R1 gate after release", gate, 1'b0);
    chk("R1 diag after release", diag, 1'b0);

    // Decode table: R2, R3, R4
    for (int i = 0; i < 9; i++) begin
      {en, cmd, vlow, ilow} = VEC[i][5:2];
      ihigh = 0; hot = 0;
      edges(8);
      chk($sformatf("R2/R3/R4 vec%0d gate", i), gate, VEC[i][1]);
      chk($sformatf("R2/R3/R4 vec%0d diag", i), diag, VEC[i][0]);
    end

    // R9: three-edge latency from the command pin to the gate
    en = 1; cmd = 0; vlow = 0; ilow = 0;
    edges(8);
    cmd = 1;
    edges(2);
    chk("R9 gate before third edge", gate, 1'b0);
    edges(1);
    chk("R9 gate at third edge", gate, 1'b1);

    // R4: undercurrent filter edge
    go_on();
    ilow = 1;
    edges(UC - 1);
    chk("R4 diag before filter expiry", diag, 1'b1);
    edges(1);
    chk("R4 diag at filter expiry", diag, 1'b0);
    chk("R4 gate stays on", gate, 1'b1);
    ilow = 0;
    edges(1);
    chk("R4 diag recovers", diag, 1'b1);

    // R5: overload window edge
    go_on();
    ihigh = 1;
    edges(OL - 1);
    chk("R5 gate before window end", gate, 1'b1);
    chk("R5 diag before window end", diag, 1'b1);
    edges(1);
    chk("R5 gate at window end", gate, 1'b0);
    chk("R5 diag at window end", diag, 1'b0);
    // R7: latch holds after flag drops
    ihigh = 0;
    edges(6);
    chk("R7 gate held off", gate, 1'b0);
    chk("R7 diag held low", diag, 1'b0);
    release_and_resume("R7");

    // R6: a one-edge gap restarts the window
    go_on();
    ihigh = 1;
    edges(OL - 1);
    ihigh = 0;
    edges(1);
    ihigh = 1;
    edges(OL - 1);
    chk("R6 gate after restart", gate, 1'b1);
    edges(1);
    chk("R6 gate at restarted window end", gate, 1'b0);
    release_and_resume("R6");

    // R8: over-temperature cut and hold
    go_on();
    hot = 1;
    edges(1);
    chk("R8 gate cut", gate, 1'b0);
    chk("R8 diag low", diag, 1'b0);
    hot = 0;
    edges(OL + 4);
    chk("R8 gate held off", gate, 1'b0);
    chk("R8 diag held low", diag, 1'b0);
    release_and_resume("R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule